// File: doc/BRIEF.md
# Double-Buffered Parallel DAC Bus Front End

This block is the digital front end of an 8-bit voltage-output converter whose analog core is a segmented current-steering array. It runs on a fast system clock and takes the converter's asynchronous bus pins: active-low select, write, load, clear and power-down, plus an 8-bit data bus. It resynchronises every pin and keeps two registers. The input register holds the word of the last completed write. The DAC register holds the word that drives the analog core.

A write cycle lasts while select and write are both low. It ends on whichever of the two rises first. The level of the load pin at that moment picks how the transfer proceeds. With load low, the DAC register follows the new word at once. With load high, the DAC register keeps its old word until the next falling edge of the load pin.

Clear holds the DAC register at zero and wins over any update in the same cycle. Power-down drives the output word to zero and raises a flag. It keeps both registers, so the held word returns when power-down is released. After reset the output stays at code zero until the first write completes. The output word is split into nibbles, and each nibble is decoded into a 15-line thermometer group. A one-cycle strobe marks every change of the DAC register.

Top module: `pdac_front`

## Requirements
- R1: A write cycle runs while `cs_n` and `wr_n` are both low. When it ends, the input register takes the value of `data_in`. This data must be stable for at least three clock cycles before the end of the cycle and one cycle after it.
- R2: If `ldac_n` is low when a write ends, `dac_code` shows the new word within 5 clock cycles of that end.
- R3: If `ldac_n` is high when a write ends, `dac_code` keeps its previous value.
- R4: A falling edge of `ldac_n` copies the input register into the DAC register. This is how a word written with `ldac_n` high reaches `dac_code`.
- R5: While `clr_n` is low, the DAC register is zero, and clear wins over any update in the same cycle. A write that ends during clear with `ldac_n` low still loads the input register. A later falling edge of `ldac_n` then shows that word.
- R6: After reset, `dac_code`, `seg_bus` and `upd_stb` are all zero. They stay zero until the first write that ends with `ldac_n` low, or until a falling edge of `ldac_n` after a completed write.
- R7: While `pd_n` is low, `pwr_down` is 1 and `dac_code` and `seg_bus` are zero. When `pd_n` rises, the word held before power-down comes back unchanged.
- R8: Bit `g*15+i` of `seg_bus` is 1 exactly when nibble g of `dac_code` is greater than i. Nibble 0 is bits 3:0 and sits in `seg_bus` bits 14:0; nibble 1 is bits 7:4 and sits in bits 29:15.
- R9: `upd_stb` pulses high for one cycle each time the DAC register changes value. A write that loads the same word produces no pulse.
- R10: A write cycle that ends because `cs_n` rises while `wr_n` is still low latches data exactly like one ended by `wr_n`.
- R11: A low pulse on `wr_n` while `cs_n` is high leaves the input register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample all bus pins |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| ldac_n | input | 1 | Active-low load; its level at the end of a write picks the mode, and its falling edge transfers data |
| clr_n | input | 1 | Active-low clear of the DAC register |
| pd_n | input | 1 | Active-low power-down request |
| data_in | input | 8 | Parallel data bus, straight binary |
| dac_code | output | 8 | Word applied to the converter core (zero in power-down) |
| seg_bus | output | 30 | Two 15-line thermometer groups, low nibble in bits 14:0 |
| upd_stb | output | 1 | One-cycle pulse when the DAC register changes |
| pwr_down | output | 1 | High while power-down is requested |

## Verification
The bench builds the block with its default parameters: 8-bit data, 4-bit segment groups and two synchronizer stages. This gives the full 30-line segment bus, where every group boundary (0x00, 0x0F, 0xF0, 0xFF) can be reached with a handful of writes. The two-stage synchronizer keeps pin-to-output latency at a few cycles, so each scenario can space its pin edges widely and still check both mode paths, clear priority and power-down restore inside short windows.

// File: rtl/pdac_pkg.sv
package pdac_pkg;
   // Order of the synchronised control pins inside the control vector
   typedef struct packed {
      logic cs_n;
      logic wr_n;
      logic ld_n;
      logic clr_n;
      logic pd_n;
   } ctl_pins_t;

   localparam int CTL_W = $bits(ctl_pins_t);

   // Kind of transfer chosen for the DAC register in one cycle
   typedef enum logic [1:0] {
      XFER_NONE  = 2'd0,
      XFER_AUTO  = 2'd1,
      XFER_LOAD  = 2'd2,
      XFER_CLEAR = 2'd3
   } xfer_e;
endpackage

// File: rtl/pdac_sync.sv
module pdac_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pdac_thermo.sv
module pdac_thermo #(
   parameter int IN_W = 4,
   localparam int LINES = (1 << IN_W) - 1
) (
   input  logic [IN_W-1:0]  code,
   output logic [LINES-1:0] therm
);
   for (genvar i = 0; i < LINES; i++) begin : g_line
      localparam logic [IN_W-1:0] LVL = IN_W'(i);
      assign therm[i] = (code > LVL);
   end
endmodule

// File: rtl/pdac_regs.sv
module pdac_regs
   import pdac_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_act,
   input  logic              ld_n_s,
   input  logic              clr_n_s,
   input  logic [DATA_W-1:0] data_early,
   output logic [DATA_W-1:0] in_reg,
   output logic [DATA_W-1:0] dac_reg,
   output logic              por,
   output logic              upd_stb,
   output logic              wr_end,
   output logic              ld_fall
);
   logic              wr_act_q;
   logic              ld_q;
   logic [DATA_W-1:0] dac_nxt;
   xfer_e             kind;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_act_q <= 1'b0;
         ld_q     <= 1'b1;
      end else begin
         wr_act_q <= wr_act;
         ld_q     <= ld_n_s;
      end
   end

   assign wr_end  = wr_act_q && !wr_act;
   assign ld_fall = ld_q && !ld_n_s;

   always_comb begin
      if (!clr_n_s)                kind = XFER_CLEAR;
      else if (wr_end && !ld_n_s)  kind = XFER_AUTO;
      else if (ld_fall)            kind = XFER_LOAD;
      else                         kind = XFER_NONE;
   end

   always_comb begin
      unique case (kind)
         XFER_CLEAR: dac_nxt = '0;
         XFER_AUTO:  dac_nxt = data_early;
         XFER_LOAD:  dac_nxt = in_reg;
         default:    dac_nxt = dac_reg;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_reg  <= '0;
         dac_reg <= '0;
         por     <= 1'b1;
         upd_stb <= 1'b0;
      end else begin
         if (wr_end) begin
            in_reg <= data_early;
            por    <= 1'b0;
         end
         dac_reg <= dac_nxt;
         upd_stb <= (dac_nxt != dac_reg);
      end
   end
endmodule

// File: rtl/pdac_front.sv
module pdac_front
   import pdac_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SEG_W       = 4,
   parameter int SYNC_STAGES = 2,
   localparam int GROUPS     = DATA_W / SEG_W,
   localparam int GRP_LINES  = (1 << SEG_W) - 1,
   localparam int SEG_TOTAL  = GROUPS * GRP_LINES
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cs_n,
   input  logic                 wr_n,
   input  logic                 ldac_n,
   input  logic                 clr_n,
   input  logic                 pd_n,
   input  logic [DATA_W-1:0]    data_in,
   output logic [DATA_W-1:0]    dac_code,
   output logic [SEG_TOTAL-1:0] seg_bus,
   output logic                 upd_stb,
   output logic                 pwr_down
);
   if (DATA_W % SEG_W != 0) begin : g_bad_split
      $error("pdac_front: DATA_W must be a multiple of SEG_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pdac_front: SYNC_STAGES must be at least 2");
   end
   if (SEG_W < 1 || SEG_W > 8) begin : g_bad_seg
      $error("pdac_front: SEG_W out of range 1..8");
   end

   ctl_pins_t         ctl_raw;
   ctl_pins_t         ctl_s;
   logic [DATA_W-1:0] data_s;
   logic [DATA_W-1:0] data_early;
   logic [DATA_W-1:0] in_reg;
   logic [DATA_W-1:0] dac_reg;
   logic              por;
   logic              wr_end;
   logic              ld_fall;
   logic              clr_q;
   logic              wr_act;

   assign ctl_raw = '{cs_n: cs_n, wr_n: wr_n, ld_n: ldac_n, clr_n: clr_n, pd_n: pd_n};

   pdac_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL({CTL_W{1'b1}})) u_ctl_sync (
      .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s)
   );

   pdac_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dat_sync (
      .clk(clk), .rst_n(rst_n), .d(data_in), .q(data_s)
   );

   // Data is taken one cycle behind the synchronised bus so the captured
   // word predates the detected end of the write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) data_early <= '0;
      else        data_early <= data_s;
   end

   assign wr_act = !ctl_s.cs_n && !ctl_s.wr_n;
   assign clr_q  = ctl_s.clr_n;

   pdac_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_act(wr_act), .ld_n_s(ctl_s.ld_n),
      .clr_n_s(ctl_s.clr_n), .data_early(data_early), .in_reg(in_reg),
      .dac_reg(dac_reg), .por(por), .upd_stb(upd_stb), .wr_end(wr_end),
      .ld_fall(ld_fall)
   );

   assign pwr_down = !ctl_s.pd_n;

   always_comb begin
      if (pwr_down)  dac_code = '0;
      else if (por)  dac_code = in_reg;
      else           dac_code = dac_reg;
   end

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      pdac_thermo #(.IN_W(SEG_W)) u_th (
         .code (dac_code[g*SEG_W +: SEG_W]),
         .therm(seg_bus[g*GRP_LINES +: GRP_LINES])
      );
   end
endmodule

// File: rtl/pdac_chk.sv
module pdac_chk #(
   parameter int DATA_W    = 8,
   parameter int SEG_W     = 4,
   parameter int SEG_TOTAL = 30
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 clr_q,
   input logic                 wr_end,
   input logic                 ld_fall,
   input logic [DATA_W-1:0]    in_reg,
   input logic [DATA_W-1:0]    dac_reg,
   input logic [DATA_W-1:0]    dac_code,
   input logic [SEG_TOTAL-1:0] seg_bus,
   input logic                 upd_stb,
   input logic                 pwr_down
);
   function automatic int nib_sum(input logic [DATA_W-1:0] c);
      int s;
      s = 0;
      for (int g = 0; g < DATA_W / SEG_W; g++)
         s += int'(c[g*SEG_W +: SEG_W]);
      return s;
   endfunction

   // R5: clear forces the DAC register to zero on the next edge
   a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_q |=> (dac_reg == '0));

   // R3: with no write end, no load edge and no clear, the register holds
   a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_q && !wr_end && !ld_fall) |=> $stable(dac_reg));

   // R4: a load edge outside a write end copies the input register
   a_r4_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_fall && clr_q && !wr_end) |=> (dac_reg == $past(in_reg)));

   // R7: power-down blanks the output word and segment bus
   a_r7_pd_blank: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |-> (dac_code == '0 && seg_bus == '0));

   // R8: thermometer population equals the sum of the nibbles
   a_r8_seg_count: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(seg_bus) == nib_sum(dac_code));

   // R9: a strobe only accompanies a real change of the DAC register
   a_r9_stb_change: assert property (@(posedge clk) disable iff (!rst_n)
      upd_stb |-> (dac_reg != $past(dac_reg)));
endmodule

bind pdac_front pdac_chk #(.DATA_W(DATA_W), .SEG_W(SEG_W), .SEG_TOTAL(SEG_TOTAL)) u_chk (
   .clk(clk), .rst_n(rst_n), .clr_q(clr_q), .wr_end(wr_end), .ld_fall(ld_fall),
   .in_reg(in_reg), .dac_reg(dac_reg), .dac_code(dac_code), .seg_bus(seg_bus),
   .upd_stb(upd_stb), .pwr_down(pwr_down)
);

// File: tb/sim_pdac_front.sv
`timescale 1ns/1ps
module sim_pdac_front;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, wr_n = 1'b1, ldac_n = 1'b1, clr_n = 1'b1, pd_n = 1'b1;
   logic [7:0]  data_in = 8'h00;
   logic [7:0]  dac_code;
   logic [29:0] seg_bus;
   logic        upd_stb;
   logic        pwr_down;

   int checks = 0;
   int fails  = 0;
   int stb_cnt = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pdac_front u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .ldac_n(ldac_n),
      .clr_n(clr_n), .pd_n(pd_n), .data_in(data_in), .dac_code(dac_code),
      .seg_bus(seg_bus), .upd_stb(upd_stb), .pwr_down(pwr_down)
   );

   always @(negedge clk) if (rst_n && upd_stb) stb_cnt++;

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000 && !done) begin
         done = 1'b1;
         fails++;
         checks++;
         $display("FAIL watchdog: run did not finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   function automatic logic [29:0] model_seg(input logic [7:0] c);
      logic [29:0] s;
      s = '0;
      for (int g = 0; g < 2; g++)
         for (int i = 0; i < 15; i++)
            s[g*15+i] = (((c >> (4*g)) & 8'h0F) > i);
      return s;
   endfunction

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // cs_first: cs_n rises before wr_n, ending the cycle (R10)
   task automatic bus_write(input logic [7:0] d, input bit cs_first);
      @(negedge clk); data_in = d;
      cyc(2); cs_n = 1'b0;
      cyc(1); wr_n = 1'b0;
      cyc(4);
      if (cs_first) cs_n = 1'b1; else wr_n = 1'b1;
      cyc(2); cs_n = 1'b1; wr_n = 1'b1;
      cyc(6);
   endtask

   task automatic ld_pulse();
      @(negedge clk); ldac_n = 1'b0;
      cyc(4); ldac_n = 1'b1;
      cyc(6);
   endtask

   task automatic expect_out(input string tag, input logic [7:0] c);
      chk({tag, " code"}, 32'(dac_code), 32'(c));
      chk({tag, " seg"}, 32'(seg_bus), 32'(model_seg(c)));
   endtask

   task automatic do_reset();
      rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; ldac_n = 1'b1; clr_n = 1'b1; pd_n = 1'b1;
      cyc(4); rst_n = 1'b1; cyc(4);
   endtask

   task automatic t_reset();   // R6
      int s0;
      do_reset();
      s0 = stb_cnt;
      expect_out("R6 reset", 8'h00);
      chk("R6 pd flag", 32'(pwr_down), 0);
      bus_write(8'h6B, 1'b0);   // ldac high: no output change
      expect_out("R6 hold after held write", 8'h00);
      chk("R6 no strobe", 32'(stb_cnt - s0), 0);
      ld_pulse();
      expect_out("R6 load after first write", 8'h6B);
   endtask

   task automatic t_auto();    // R1 R2 R9
      int s0;
      @(negedge clk); ldac_n = 1'b0; cyc(6);
      s0 = stb_cnt;
      bus_write(8'hA5, 1'b0);
      expect_out("R1 R2 auto update", 8'hA5);
      chk("R9 one strobe", 32'(stb_cnt - s0), 1);
      s0 = stb_cnt;
      bus_write(8'hA5, 1'b0);
      chk("R9 same word no strobe", 32'(stb_cnt - s0), 0);
   endtask

   task automatic t_sync();    // R3 R4 R10 R11
      int s0;
      @(negedge clk); ldac_n = 1'b1; cyc(6);
      bus_write(8'h3C, 1'b0);
      expect_out("R3 held write", 8'hA5);
      s0 = stb_cnt;
      ld_pulse();
      expect_out("R4 load edge", 8'h3C);
      chk("R4 R9 strobe on load", 32'(stb_cnt - s0), 1);
      bus_write(8'h5E, 1'b1);
      ld_pulse();
      expect_out("R10 cs ends cycle", 8'h5E);
      @(negedge clk); data_in = 8'hFF;
      cyc(3); wr_n = 1'b0; cyc(4); wr_n = 1'b1; cyc(6);
      ld_pulse();
      expect_out("R11 write without select", 8'h5E);
   endtask

   task automatic t_clear();   // R5
      @(negedge clk); clr_n = 1'b0; cyc(6);
      expect_out("R5 clear", 8'h00);
      @(negedge clk); ldac_n = 1'b0; cyc(6);
      bus_write(8'h81, 1'b0);
      expect_out("R5 auto write under clear", 8'h00);
      @(negedge clk); clr_n = 1'b1; ldac_n = 1'b1; cyc(6);
      expect_out("R5 after release", 8'h00);
      ld_pulse();
      expect_out("R5 loaded word survives", 8'h81);
   endtask

   task automatic t_pd();      // R7
      @(negedge clk); pd_n = 1'b0; cyc(6);
      chk("R7 flag", 32'(pwr_down), 1);
      expect_out("R7 blank", 8'h00);
      @(negedge clk); pd_n = 1'b1; cyc(6);
      chk("R7 flag off", 32'(pwr_down), 0);
      expect_out("R7 restore", 8'h81);
   endtask

   task automatic t_segs();    // R8
      logic [7:0] pats [4] = '{8'hFF, 8'h00, 8'h0F, 8'hF0};
      @(negedge clk); ldac_n = 1'b0; cyc(6);
      foreach (pats[k]) begin
         bus_write(pats[k], 1'b0);
         expect_out("R8 segment boundary", pats[k]);
      end
      @(negedge clk); ldac_n = 1'b1; cyc(4);
   endtask

   initial begin
      t_reset();
      t_auto();
      t_sync();
      t_clear();
      t_pd();
      t_segs();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule